// File: doc/BRIEF.md
# Variable-Rate BCD Up/Down Counter

This block is a two-digit decimal counter whose stepping rate is set at run time from push buttons. A fixed two-stage prescaler turns the system clock into a slow tick. With the default 2 MHz clock it divides by 625 to reach 3200 Hz, then by 32 to reach 100 Hz. A third divider, whose ratio runs from 1 to 16, divides that tick further. Each pulse out of the third divider moves the decimal count one place, up or down. Every register runs on the one system clock, and the slower stages advance through one-cycle enable pulses.

Five raw buttons control the counter. They pass through a synchronizer and a debouncer that samples on the slow tick. One press flips the counting direction. One press makes the divider ratio larger, so the count runs slower. One press makes the ratio smaller, so the count runs faster. Holding the hold button freezes the count. One press switches the display view. Four seven-segment outputs show either the decimal count, with each digit on two displays, or the divider's ratio code and its current count.

Top module: `bcd_rate_counter`

## Requirements
- R1: After reset the count is 00, the ratio is 1, the direction is up and the view shows the count.
- R2: While not held, the count moves exactly once every DIV1*DIV2*ratio clock cycles.
- R3: Counting up, the units digit goes 9 to 0, and at that step the tens digit goes up by one whatever its value. 99 is followed by 00. Neither digit ever exceeds 9.
- R4: Counting down, the units digit goes 0 to 9, and at that step the tens digit goes down by one. 00 is followed by 99.
- R5: Each accepted press of the direction button flips the direction once.
- R6: Each accepted press of the slower button raises the ratio by one, up to 16. Each accepted press of the faster button lowers it by one, down to 1. A press at a limit leaves the ratio unchanged.
- R7: While the hold button is accepted as pressed, the count does not change. Counting resumes after release.
- R8: A button level is accepted only after it differs from the accepted level on 3 consecutive slow ticks. A shorter pulse has no effect.
- R9: Each press of the view button toggles the view. In ratio view, seg3 and seg2 show ratio-1 as a hex digit (0 to F). seg1 and seg0 show the divider's current count, which is never more than ratio-1.
- R10: Segment vectors are active high with bit 0 = a through bit 6 = g, using the usual hex shapes. Digit 2 is 7'h5B, so segment f (bit 5) is off. In count view, seg3 and seg2 both show the tens digit, and seg1 and seg0 both show the units digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_dir | input | 1 | Raw button, flips direction (high = pressed) |
| btn_slower | input | 1 | Raw button, raises ratio |
| btn_faster | input | 1 | Raw button, lowers ratio |
| btn_hold | input | 1 | Raw button, freezes count while held |
| btn_view | input | 1 | Raw button, toggles view |
| seg3 | output | 7 | Display 3 segments (tens or ratio code) |
| seg2 | output | 7 | Display 2 segments (tens or ratio code) |
| seg1 | output | 7 | Display 1 segments (units or divider count) |
| seg0 | output | 7 | Display 0 segments (units or divider count) |

## Verification
The bench shrinks both prescalers to 2, so one slow tick takes 4 clocks. It then follows every decimal transition in both directions through two full wraps. This catches a carry that depends on tens-digit parity, a missed 99-to-00 or 00-to-99 wrap, and a missing borrow. It times the step interval for every ratio from 1 to 16, which catches an off-by-one divider. It drives the ratio into both limits, where a wrong design would wrap from 16 to 1. It also checks that a pulse shorter than three ticks is rejected, that a hold freezes the count, and that the digit 2 shape keeps segment f dark.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef logic [3:0] nib_t;
  typedef logic [6:0] seg_t;
  localparam int BTN_DIR    = 0;
  localparam int BTN_SLOWER = 1;
  localparam int BTN_FASTER = 2;
  localparam int BTN_HOLD   = 3;
  localparam int BTN_VIEW   = 4;
  localparam int NUM_BTN    = 5;
endpackage

// File: rtl/rc_tick_div.sv
module rc_tick_div #(
  parameter int DIV = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = en && (cnt_q == LAST);

  // R2: the counter never passes its terminal value
  p_div_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/rc_debounce.sv
module rc_debounce #(
  parameter int TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic sample_en,
  output logic level,
  output logic press
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          press_q;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (s2_q == lvl_q) begin
      cnt_d = '0;
    end else if (sample_en) begin
      if (cnt_q == LAST) begin
        lvl_d = s2_q;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      cnt_q   <= '0;
      lvl_q   <= 1'b0;
      press_q <= 1'b0;
    end else begin
      s1_q    <= raw;
      s2_q    <= s1_q;
      cnt_q   <= cnt_d;
      lvl_q   <= lvl_d;
      press_q <= lvl_d && !lvl_q;
    end
  end

  assign level = lvl_q;
  assign press = press_q;

  // R8: the accepted level only moves on a sample tick
  p_deb_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> $past(sample_en));
endmodule

// File: rtl/rc_rate_div.sv
module rc_rate_div #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_in,
  input  logic          hold,
  input  logic [RW-1:0] ratio_code,
  input  logic          reload,
  output logic          step,
  output logic [RW-1:0] cnt
);
  logic [RW-1:0] cnt_q, cnt_d;
  logic          adv;

  assign adv = tick_in && !hold;

  always_comb begin
    cnt_d = cnt_q;
    if (reload)   cnt_d = '0;
    else if (adv) cnt_d = (cnt_q == ratio_code) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign step = adv && (cnt_q == ratio_code);
  assign cnt  = cnt_q;

  // R9: divider count stays within the current ratio
  p_divcnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ratio_code);
  // R7: no step leaves the divider while held
  p_hold_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !step);
endmodule

// File: rtl/rc_bcd_count.sv
module rc_bcd_count #(
  parameter int DIGITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                up,
  output logic [4*DIGITS-1:0] value
);
  logic [DIGITS-1:0][3:0] dig_q, dig_d;
  logic [DIGITS:0]        roll;

  assign roll[0] = step;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign roll[i+1] = roll[i] && (up ? (dig_q[i] == 4'd9) : (dig_q[i] == 4'd0));
    always_comb begin
      dig_d[i] = dig_q[i];
      if (roll[i]) begin
        if (up) dig_d[i] = (dig_q[i] == 4'd9) ? 4'd0 : dig_q[i] + 4'd1;
        else    dig_d[i] = (dig_q[i] == 4'd0) ? 4'd9 : dig_q[i] - 4'd1;
      end
    end
    assign value[4*i +: 4] = dig_q[i];

    // R3: every digit stays a decimal digit
    p_digit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dig_q[i] <= 4'd9);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dig_q <= '0;
    else        dig_q <= dig_d;
  end

  // R7: the count holds when no step arrives
  p_no_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(dig_q));

  if (DIGITS > 1) begin : g_carry_chk
    // R3: units 9->0 carries into tens regardless of tens parity
    p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && up && dig_q[0] == 4'd9) |=>
        (dig_q[1] == (($past(dig_q[1]) == 4'd9) ? 4'd0 : $past(dig_q[1]) + 4'd1)));
    // R4: units 0->9 borrows from tens
    p_borrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !up && dig_q[0] == 4'd0) |=>
        (dig_q[1] == (($past(dig_q[1]) == 4'd0) ? 4'd9 : $past(dig_q[1]) - 4'd1)));
  end
endmodule

// File: rtl/rc_seg7.sv
module rc_seg7 (
  input  rc_pkg::nib_t nib,
  output rc_pkg::seg_t seg
);
  always_comb begin
    case (nib)
      4'h0: seg = 7'h3F;
      4'h1: seg = 7'h06;
      4'h2: seg = 7'h5B;
      4'h3: seg = 7'h4F;
      4'h4: seg = 7'h66;
      4'h5: seg = 7'h6D;
      4'h6: seg = 7'h7D;
      4'h7: seg = 7'h07;
      4'h8: seg = 7'h7F;
      4'h9: seg = 7'h6F;
      4'hA: seg = 7'h77;
      4'hB: seg = 7'h7C;
      4'hC: seg = 7'h39;
      4'hD: seg = 7'h5E;
      4'hE: seg = 7'h79;
      default: seg = 7'h71;
    endcase
  end

  // R10: the shape for 2 keeps segment f dark
  always_comb a_two_no_f_r10: assert (!(nib == 4'h2 && seg[5]));
endmodule

// File: rtl/bcd_rate_counter.sv
module bcd_rate_counter #(
  parameter int DIV1      = 625,
  parameter int DIV2      = 32,
  parameter int RATIO_MAX = 16,
  parameter int DEB_TICKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_dir,
  input  logic       btn_slower,
  input  logic       btn_faster,
  input  logic       btn_hold,
  input  logic       btn_view,
  output logic [6:0] seg3,
  output logic [6:0] seg2,
  output logic [6:0] seg1,
  output logic [6:0] seg0
);
  import rc_pkg::*;
  localparam int RW = (RATIO_MAX > 1) ? $clog2(RATIO_MAX) : 1;
  localparam logic [RW-1:0] CODE_TOP = RW'(RATIO_MAX - 1);

  logic rs1_q, rs2_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  logic tick_a, tick_b;
  rc_tick_div #(.DIV(DIV1)) u_pre1 (.clk(clk), .rst_n(rst_i_n), .en(1'b1),   .tick(tick_a));
  rc_tick_div #(.DIV(DIV2)) u_pre2 (.clk(clk), .rst_n(rst_i_n), .en(tick_a), .tick(tick_b));

  logic [NUM_BTN-1:0] raw_btn, lvl, prs;
  assign raw_btn = {btn_view, btn_hold, btn_faster, btn_slower, btn_dir};

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    rc_debounce #(.TICKS(DEB_TICKS)) u_deb (
      .clk(clk), .rst_n(rst_i_n), .raw(raw_btn[b]), .sample_en(tick_b),
      .level(lvl[b]), .press(prs[b]));
  end

  logic          up_q, up_d, view_q, view_d;
  logic [RW-1:0] code_q, code_d;

  always_comb begin
    up_d   = prs[BTN_DIR]  ? !up_q   : up_q;
    view_d = prs[BTN_VIEW] ? !view_q : view_q;
    code_d = code_q;
    if (prs[BTN_SLOWER] && !prs[BTN_FASTER] && code_q != CODE_TOP)
      code_d = code_q + 1'b1;
    else if (prs[BTN_FASTER] && !prs[BTN_SLOWER] && code_q != '0)
      code_d = code_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      up_q   <= 1'b1;
      view_q <= 1'b0;
      code_q <= '0;
    end else begin
      up_q   <= up_d;
      view_q <= view_d;
      code_q <= code_d;
    end
  end

  logic          step;
  logic [RW-1:0] div_cnt;
  rc_rate_div #(.RW(RW)) u_rate (
    .clk(clk), .rst_n(rst_i_n), .tick_in(tick_b), .hold(lvl[BTN_HOLD]),
    .ratio_code(code_q), .reload(prs[BTN_SLOWER] | prs[BTN_FASTER]),
    .step(step), .cnt(div_cnt));

  logic [7:0] bcd;
  rc_bcd_count #(.DIGITS(2)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .step(step), .up(up_q), .value(bcd));

  nib_t [3:0] nib;
  seg_t [3:0] seg;
  always_comb begin
    if (view_q) begin
      nib[3] = nib_t'(code_q);
      nib[2] = nib_t'(code_q);
      nib[1] = nib_t'(div_cnt);
      nib[0] = nib_t'(div_cnt);
    end else begin
      nib[3] = bcd[7:4];
      nib[2] = bcd[7:4];
      nib[1] = bcd[3:0];
      nib[0] = bcd[3:0];
    end
  end

  for (genvar d = 0; d < 4; d++) begin : g_seg
    rc_seg7 u_dec (.nib(nib[d]), .seg(seg[d]));
  end

  assign seg3 = seg[3];
  assign seg2 = seg[2];
  assign seg1 = seg[1];
  assign seg0 = seg[0];

  // R6: ratio code moves by at most one and only on an adjust press
  p_ratio_step_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (code_q != $past(code_q)) |->
      ($past(prs[BTN_SLOWER] | prs[BTN_FASTER]) &&
       (code_q == $past(code_q) + 1'b1 || code_q == $past(code_q) - 1'b1)));
  // R5: direction flips only on a direction press
  p_dir_flip_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (up_q != $past(up_q)) |-> $past(prs[BTN_DIR]));
  // R7: held count produces no step
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    lvl[BTN_HOLD] |-> !step);
endmodule

// File: tb/sim_bcd_rate_counter.sv
module sim_bcd_rate_counter;
  localparam int TPER = 4; // DIV1*DIV2 in this configuration

  logic clk = 1'b0;
  logic rst_n;
  logic b_dir, b_slow, b_fast, b_hold, b_view;
  logic [6:0] s3, s2, s1, s0;
  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bcd_rate_counter #(.DIV1(2), .DIV2(2), .RATIO_MAX(16), .DEB_TICKS(3)) u0 (
    .clk(clk), .rst_n(rst_n), .btn_dir(b_dir), .btn_slower(b_slow),
    .btn_faster(b_fast), .btn_hold(b_hold), .btn_view(b_view),
    .seg3(s3), .seg2(s2), .seg1(s1), .seg0(s0));

  function automatic int dec(input logic [6:0] s);
    case (s)
      7'h3F: return 0;  7'h06: return 1;  7'h5B: return 2;  7'h4F: return 3;
      7'h66: return 4;  7'h6D: return 5;  7'h7D: return 6;  7'h07: return 7;
      7'h7F: return 8;  7'h6F: return 9;  7'h77: return 10; 7'h7C: return 11;
      7'h39: return 12; 7'h5E: return 13; 7'h79: return 14; 7'h71: return 15;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int count_val();
    int t, u;
    t = dec(s3); u = dec(s1);
    if (t < 0 || u < 0 || t > 9 || u > 9 || s3 != s2 || s1 != s0) return -1;
    return t * 10 + u;
  endfunction

  task automatic press(ref logic b);
    b = 1'b1; tk(30);
    b = 1'b0; tk(30);
  endtask

  // follow n count changes; check successor (R3/R4), interval (R2), digit 2 shape (R10)
  task automatic track(input int n, input bit up, input int r);
    int prev, cur, last_t, k;
    bit first;
    prev = count_val(); last_t = cyc; first = 1; k = 0;
    while (k < n) begin
      int waited;
      waited = 0;
      do begin tk(1); waited++; cur = count_val(); end
      while (cur == prev && waited < 8 * TPER * r + 40);
      if (cur == prev) begin
        chk(0, "R2 no step seen", cur, prev);
        return;
      end
      if (up) chk(cur == (prev + 1) % 100, "R3 up successor", cur, (prev + 1) % 100);
      else    chk(cur == (prev + 99) % 100, "R4 down successor", cur, (prev + 99) % 100);
      if (!first) chk(cyc - last_t == TPER * r, "R2 step interval", cyc - last_t, TPER * r);
      if (cur % 10 == 2) chk(s1 == 7'h5B && !s1[5], "R10 digit 2 shape", s1, 7'h5B);
      first = 0; last_t = cyc; prev = cur; k++;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v1, v2;
    rst_n = 1'b0;
    b_dir = 0; b_slow = 0; b_fast = 0; b_hold = 0; b_view = 0;
    tk(5);
    rst_n = 1'b1;
    tk(3);
    // R1 reset state
    chk(count_val() == 0, "R1 reset count", count_val(), 0);
    chk(s3 == 7'h3F && s2 == 7'h3F, "R10 reset tens on two displays", s3, 7'h3F);
    // R1 / R2 / R3: up at ratio 1 through two wraps
    track(210, 1'b1, 1);
    // R5: direction press, then down through wraps
    press(b_dir);
    track(210, 1'b0, 1);
    press(b_dir);
    track(12, 1'b1, 1);
    // R6 / R2: ratio sweep
    for (int r = 2; r <= 16; r++) begin
      press(b_slow);
      track(3, 1'b1, r);
    end
    // R9 / R6: view ratio and saturation at top
    press(b_view);
    chk(dec(s3) == 15 && s3 == s2, "R9 ratio code at 16", dec(s3), 15);
    press(b_slow);
    chk(dec(s3) == 15, "R6 saturate at 16", dec(s3), 15);
    for (int i = 0; i < 40; i++) begin
      tk(3);
      chk(dec(s1) >= 0 && dec(s1) <= 15 && s1 == s0, "R9 divider count range", dec(s1), 15);
    end
    for (int i = 0; i < 15; i++) press(b_fast);
    chk(dec(s3) == 0, "R6 back to ratio 1", dec(s3), 0);
    press(b_fast);
    chk(dec(s3) == 0, "R6 saturate at 1", dec(s3), 0);
    for (int i = 0; i < 10; i++) begin
      tk(1);
      chk(dec(s1) == 0, "R9 divider count at ratio 1", dec(s1), 0);
    end
    press(b_slow); press(b_slow);
    chk(dec(s3) == 2, "R6 two raises", dec(s3), 2);
    for (int i = 0; i < 30; i++) begin
      tk(1);
      chk(dec(s1) >= 0 && dec(s1) <= 2, "R9 divider count below ratio 3", dec(s1), 2);
    end
    press(b_fast); press(b_fast);
    press(b_view);
    chk(count_val() >= 0, "R9 back to count view", count_val(), 0);
    track(5, 1'b1, 1);
    // R8: short glitch on direction ignored
    b_dir = 1'b1; tk(5); b_dir = 1'b0; tk(20);
    track(20, 1'b1, 1);
    // R8: short glitch on view ignored
    b_view = 1'b1; tk(5); b_view = 1'b0; tk(20);
    chk(count_val() >= 0, "R8 view glitch ignored", count_val(), 0);
    // R7: hold freezes count
    b_hold = 1'b1; tk(40);
    v1 = count_val(); tk(120); v2 = count_val();
    chk(v1 == v2 && v1 >= 0, "R7 hold freezes", v2, v1);
    b_hold = 1'b0; tk(30);
    track(6, 1'b1, 1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule